// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a clocked host and an asynchronous byte-wide static RAM of 32K locations. The host hands over one word request at a time on a valid/ready port: a 15-bit address, a write flag and, for writes, a data byte. The controller turns each request into a timed sequence of chip-select, output-enable and write-enable strobes. It drives the address and a split data bus (data out, a drive enable and data in) that a pad ring joins into the bidirectional pins. Read data comes back on a one-clock return strobe.

Every phase length is derived at elaboration time from the memory's minimum timing values, which are given in nanoseconds next to a clock period parameter. Each value is rounded up to whole clocks, and every phase lasts at least one clock. A write always keeps output-enable high. It starts with a turnaround phase that lets a read still on the bus drain. The controller's data drivers are on only while write-enable is low, and they switch off on the same edge that ends the write. Between requests the chip select is high, so the memory sits in its low-power standby. An optional linger count keeps it selected for a few idle clocks so that closely spaced accesses avoid power-up delay.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset, `sram_ce_n`, `sram_oe_n` and `sram_we_n` are 1, `sram_dq_oe` and `rd_valid` are 0, and `req_ready` is 1.
- R2: A read is accepted on the clock edge where `req_valid` and `req_ready` are both 1 and `req_write` is 0. From that edge, `sram_ce_n`=0, `sram_oe_n`=0 and `sram_we_n`=1 hold with the request address on `sram_addr` for RD clocks, where RD is the largest of ceil(tAA/Tclk), ceil(tDOE/Tclk) and ceil(tRC/Tclk). Each ceiling is taken as at least 1.
- R3: A write (`req_write`=1) is accepted on such an edge and runs three phases. First comes a turnaround of ceil(tHZOE/Tclk) clocks with CE low, WE high and the drivers off. Next comes a pulse of PW clocks with WE low, `sram_dq_oe`=1 and the write byte on `sram_dq_o`. PW is the largest of the ceilings of tPWE, tSD and tAW, raised if needed so the whole write spans at least ceil(tWC/Tclk) clocks. Last comes one hold clock with CE low, WE high and the drivers off. A later read of that address returns the byte.
- R4: `sram_oe_n` is 1 during every clock in which `sram_we_n` is 0, and `sram_dq_oe` is 1 only while `sram_we_n` is 0.
- R5: `sram_dq_oe` is never 1 while the memory can drive the bus, i.e. while CE and OE are both low.
- R6: `sram_addr` and `sram_dq_o` do not change between the clock after acceptance and the end of the access.
- R7: `req_ready` is 0 from the acceptance edge until the access ends. A request held valid in that time is not taken and leaves the address outputs unchanged.
- R8: When an access ends and no request is taken, `sram_ce_n` returns to 1 at once if CE_LINGER_CLKS is 0. Otherwise it stays 0 for CE_LINGER_CLKS idle clocks and then returns to 1.
- R9: The byte on `sram_dq_i` is captured into `rd_data` on the last edge of the read phase. `rd_valid` is 1 for exactly the one clock after that edge, and never for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-clock strobe marking `rd_data` as new |
| rd_data | output | 8 | Captured read byte |
| sram_ce_n | output | 1 | Memory chip select, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_addr | output | 15 | Memory address |
| sram_dq_o | output | 8 | Data toward the memory |
| sram_dq_oe | output | 1 | Drive enable for `sram_dq_o` onto the pins |
| sram_dq_i | input | 8 | Data from the memory pins |

## Verification
Counted from the acceptance edge, the read strobes last RD clocks and `rd_valid` with its data is due RD clocks later. A write's WE-low window starts after the turnaround count and lasts PW clocks, and `req_ready` returns one hold clock after that. The bench computes these counts from the same nanosecond values with its own ceiling function. It samples every output on the falling edge that follows each rising edge, with the clock index counted from acceptance, so each strobe is compared in exactly the clock it is due. A bench memory model commits a byte on the clock where the write window closes and checks at every falling edge that the two sides never drive the bus together.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD       = 3'd1,
    ST_WR_TURN  = 3'd2,
    ST_WR_PULSE = 3'd3,
    ST_WR_HOLD  = 3'd4
  } ctrl_state_e;

  // Round a time in ns up to whole clocks, never below one clock.
  function automatic int unsigned ns_to_clk(int unsigned t_ns, int unsigned per_ns);
    int unsigned c;
    c = (t_ns + per_ns - 1) / per_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_cnt.sv
module sram_phase_cnt #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic [CW-1:0] count
);

  logic [CW-1:0] count_nx;

  always_comb begin
    if (restart) count_nx = '0;
    else         count_nx = count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_nx;
  end

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [DW-1:0] dq_in,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= cap_en;
      if (cap_en) rd_data <= dq_in;
    end
  end

  // R9: the return strobe never lasts two clocks
  p_rdv_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

endmodule

// File: rtl/sram_strobe_fsm.sv
module sram_strobe_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int AW             = 15,
  parameter int DW             = 8,
  parameter int CW             = 4,
  parameter int RD_CLKS        = 3,
  parameter int TURN_CLKS      = 2,
  parameter int PULSE_CLKS     = 2,
  parameter int CE_LINGER_CLKS = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  input  logic [CW-1:0] phase_cnt,
  output logic          phase_restart,
  output logic          cap_en,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n,
  output logic          dq_oe,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q
);

  localparam int LGW = (CE_LINGER_CLKS > 0) ? $clog2(CE_LINGER_CLKS + 1) : 1;
  localparam logic [LGW-1:0] LG_LOAD = LGW'(CE_LINGER_CLKS);

  ctrl_state_e   state_q, state_nx;
  logic [CW-1:0] phase_len;
  logic          phase_last;
  logic          accept;
  logic [LGW-1:0] lg_q, lg_nx;
  logic          ce_n_nx, oe_n_nx, we_n_nx, dq_oe_nx;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;

  always_comb begin
    case (state_q)
      ST_RD:       phase_len = CW'(RD_CLKS);
      ST_WR_TURN:  phase_len = CW'(TURN_CLKS);
      ST_WR_PULSE: phase_len = CW'(PULSE_CLKS);
      default:     phase_len = CW'(1);
    endcase
  end

  assign phase_last = (phase_cnt == phase_len - CW'(1));

  always_comb begin
    state_nx = state_q;
    case (state_q)
      ST_IDLE:     if (req_valid) state_nx = req_write ? ST_WR_TURN : ST_RD;
      ST_RD:       if (phase_last) state_nx = ST_IDLE;
      ST_WR_TURN:  if (phase_last) state_nx = ST_WR_PULSE;
      ST_WR_PULSE: if (phase_last) state_nx = ST_WR_HOLD;
      ST_WR_HOLD:  state_nx = ST_IDLE;
      default:     state_nx = ST_IDLE;
    endcase
  end

  assign phase_restart = (state_nx != state_q) || (state_q == ST_IDLE);
  assign cap_en        = (state_q == ST_RD) && phase_last;

  always_comb begin
    lg_nx = lg_q;
    if (state_q != ST_IDLE && state_nx == ST_IDLE) lg_nx = LG_LOAD;
    else if (state_nx != ST_IDLE)                  lg_nx = '0;
    else if (lg_q != '0)                           lg_nx = lg_q - 1'b1;
  end

  always_comb begin
    ce_n_nx  = (state_nx == ST_IDLE) && (lg_nx == '0);
    oe_n_nx  = (state_nx != ST_RD);
    we_n_nx  = (state_nx != ST_WR_PULSE);
    dq_oe_nx = (state_nx == ST_WR_PULSE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lg_q    <= '0;
      ce_n    <= 1'b1;
      oe_n    <= 1'b1;
      we_n    <= 1'b1;
      dq_oe   <= 1'b0;
    end else begin
      state_q <= state_nx;
      lg_q    <= lg_nx;
      ce_n    <= ce_n_nx;
      oe_n    <= oe_n_nx;
      we_n    <= we_n_nx;
      dq_oe   <= dq_oe_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      if (accept)              addr_q  <= req_addr;
      if (accept && req_write) wdata_q <= req_wdata;
    end
  end

  // Run-length counters used only by the checks below.
  logic [CW-1:0] we_run, oe_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run <= '0;
      oe_run <= '0;
    end else begin
      we_run <= we_n ? '0 : we_run + 1'b1;
      oe_run <= oe_n ? '0 : oe_run + 1'b1;
    end
  end

  p_oe_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_n) |-> (oe_run == CW'(RD_CLKS)));

  p_we_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (we_run == CW'(PULSE_CLKS)));

  p_strobe_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n || !we_n) |-> !ce_n);

  p_we_oe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe_n);

  p_drv_in_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !we_n);

  p_no_contend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (oe_n || ce_n));

  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> ($stable(addr_q) && $stable(wdata_q)));

  p_busy_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> !ce_n);

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW             = 15,
  parameter int DW             = 8,
  parameter int CLK_PERIOD_NS  = 5,
  parameter int T_RC_NS        = 15,
  parameter int T_AA_NS        = 15,
  parameter int T_DOE_NS       = 7,
  parameter int T_WC_NS        = 15,
  parameter int T_PWE_NS       = 9,
  parameter int T_SD_NS        = 9,
  parameter int T_AW_NS        = 10,
  parameter int T_HZOE_NS      = 7,
  parameter int CE_LINGER_CLKS = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          sram_ce_n,
  output logic          sram_oe_n,
  output logic          sram_we_n,
  output logic [AW-1:0] sram_addr,
  output logic [DW-1:0] sram_dq_o,
  output logic          sram_dq_oe,
  input  logic [DW-1:0] sram_dq_i
);

  localparam int unsigned P       = CLK_PERIOD_NS;
  localparam int RD_CLKS   = max2(max2(ns_to_clk(T_AA_NS, P), ns_to_clk(T_DOE_NS, P)),
                                  ns_to_clk(T_RC_NS, P));
  localparam int TURN_CLKS = ns_to_clk(T_HZOE_NS, P);
  localparam int WC_CLKS   = ns_to_clk(T_WC_NS, P);
  localparam int WC_REST   = (WC_CLKS > TURN_CLKS + 1) ? WC_CLKS - TURN_CLKS - 1 : 1;
  localparam int PULSE_CLKS = max2(max2(ns_to_clk(T_PWE_NS, P), ns_to_clk(T_SD_NS, P)),
                                   max2(ns_to_clk(T_AW_NS, P), WC_REST));
  localparam int MAX_PHASE = max2(max2(RD_CLKS, TURN_CLKS), PULSE_CLKS);
  localparam int CW        = $clog2(MAX_PHASE + 1) + 1;

  logic [CW-1:0] phase_cnt;
  logic          phase_restart;
  logic          cap_en;

  sram_phase_cnt #(.CW(CW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (phase_restart),
    .count   (phase_cnt)
  );

  sram_strobe_fsm #(
    .AW             (AW),
    .DW             (DW),
    .CW             (CW),
    .RD_CLKS        (RD_CLKS),
    .TURN_CLKS      (TURN_CLKS),
    .PULSE_CLKS     (PULSE_CLKS),
    .CE_LINGER_CLKS (CE_LINGER_CLKS)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_wdata     (req_wdata),
    .req_ready     (req_ready),
    .phase_cnt     (phase_cnt),
    .phase_restart (phase_restart),
    .cap_en        (cap_en),
    .ce_n          (sram_ce_n),
    .oe_n          (sram_oe_n),
    .we_n          (sram_we_n),
    .dq_oe         (sram_dq_oe),
    .addr_q        (sram_addr),
    .wdata_q       (sram_dq_o)
  );

  sram_rd_capture #(.DW(DW)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .dq_in    (sram_dq_i),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

endmodule

// File: tb/sram_strobe_ctrl_tb.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_tb;

  localparam int PER = 5;
  localparam int LG  = 3;

  function automatic int clks(int ns);
    int c;
    c = (ns + PER - 1) / PER;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD    = mx(mx(clks(15), clks(7)), clks(15));
  localparam int TURN  = clks(7);
  localparam int WREST = (clks(15) > TURN + 1) ? clks(15) - TURN - 1 : 1;
  localparam int PW    = mx(mx(clks(9), clks(9)), mx(clks(10), WREST));
  localparam int WEND  = TURN + PW + 1;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write;
  logic [14:0] req_addr;
  logic [7:0]  req_wdata;
  logic req_ready, rd_valid, ce_n, oe_n, we_n, dq_oe;
  logic [7:0] rd_data, dq_o, dq_i;
  logic [14:0] s_addr;
  logic lg_ready, lg_rdv, lg_ce_n, lg_oe_n, lg_we_n, lg_dq_oe;
  logic [7:0] lg_rdata, lg_dq_o;
  logic [14:0] lg_addr;

  int checks = 0, errors = 0, cycles = 0, contend = 0;
  bit [7:0] ref_mem [int];
  bit [7:0] sram_mem [int];

  always #(PER/2.0) clk = ~clk;

  sram_strobe_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .sram_ce_n(ce_n), .sram_oe_n(oe_n),
    .sram_we_n(we_n), .sram_addr(s_addr), .sram_dq_o(dq_o), .sram_dq_oe(dq_oe),
    .sram_dq_i(dq_i));

  sram_strobe_ctrl #(.CE_LINGER_CLKS(LG)) u_dut_lg (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(lg_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(lg_rdv), .rd_data(lg_rdata), .sram_ce_n(lg_ce_n), .sram_oe_n(lg_oe_n),
    .sram_we_n(lg_we_n), .sram_addr(lg_addr), .sram_dq_o(lg_dq_o), .sram_dq_oe(lg_dq_oe),
    .sram_dq_i(8'h00));

  function automatic bit [7:0] init_val(int a);
    return 8'(a) ^ 8'(a >> 8) ^ 8'h5A;
  endfunction
  function automatic bit [7:0] ref_rd(int a);
    return ref_mem.exists(a) ? ref_mem[a] : init_val(a);
  endfunction

  // Memory model, evaluated away from the active edge.
  logic p_wr_win, p_dq_oe;
  logic [14:0] p_addr;
  logic [7:0]  p_dq;
  always @(negedge clk) begin
    if (p_wr_win && (we_n || ce_n))
      sram_mem[int'(p_addr)] = p_dq_oe ? p_dq : 8'hEE;
    p_wr_win = !we_n && !ce_n;
    p_dq_oe  = dq_oe;
    p_addr   = s_addr;
    p_dq     = dq_o;
    if (!ce_n && !oe_n && we_n) begin
      dq_i = sram_mem.exists(int'(s_addr)) ? sram_mem[int'(s_addr)] : init_val(int'(s_addr));
      if (dq_oe) contend++;
    end else begin
      dq_i = 8'hEE;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    chk(contend == 0, "R5", "bus contention cycles", contend, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Called at a falling edge with the controller idle.
  task automatic do_read(int a, bit poke);
    bit [7:0] exp;
    exp = ref_rd(a);
    chk(req_ready == 1'b1, "R7", "ready before read", req_ready, 1);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 15'(a);
    @(posedge clk);
    for (int j = 0; j <= RD; j++) begin
      @(negedge clk);
      if (j == 0) begin
        if (poke) req_addr = 15'(a) ^ 15'h1;
        else      req_valid = 1'b0;
      end
      if (j == RD - 1) req_valid = 1'b0;
      if (j < RD) begin
        chk(!ce_n && !oe_n && we_n, "R2", "read strobes", {ce_n, oe_n, we_n}, 3'b001);
        chk(s_addr == 15'(a), poke ? "R7" : "R2", "read address", s_addr, a);
        chk(!req_ready && !rd_valid, "R7", "busy during read", {req_ready, rd_valid}, 0);
        chk(!dq_oe, "R5", "drivers off during read", dq_oe, 0);
      end else begin
        chk(rd_valid == 1'b1, "R9", "rd_valid due", rd_valid, 1);
        chk(rd_data == exp, "R9", "read data", rd_data, exp);
        chk(oe_n && ce_n, "R8", "deselect after read", {ce_n, oe_n}, 2'b11);
      end
    end
  endtask

  task automatic do_write(int a, bit [7:0] d);
    chk(req_ready == 1'b1, "R7", "ready before write", req_ready, 1);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 15'(a); req_wdata = d;
    @(posedge clk);
    for (int j = 0; j <= WEND; j++) begin
      @(negedge clk);
      if (j == 0) begin req_valid = 1'b0; req_wdata = ~d; end
      if (j < TURN) begin
        chk(!ce_n && we_n && oe_n && !dq_oe, "R3", "turnaround", {ce_n, we_n, oe_n, dq_oe}, 4'b0110);
      end else if (j < TURN + PW) begin
        chk(!ce_n && !we_n && oe_n && dq_oe, "R4", "write pulse", {ce_n, we_n, oe_n, dq_oe}, 4'b0011);
        chk(dq_o == d, "R6", "write data", dq_o, d);
      end else if (j == TURN + PW) begin
        chk(!ce_n && we_n && !dq_oe, "R3", "write hold", {ce_n, we_n, dq_oe}, 3'b010);
      end else begin
        chk(ce_n && req_ready, "R8", "deselect after write", {ce_n, req_ready}, 2'b11);
        chk(!rd_valid, "R9", "no rd_valid on write", rd_valid, 0);
      end
      if (j < WEND) begin
        chk(s_addr == 15'(a), "R6", "write address", s_addr, a);
        chk(!req_ready, "R7", "busy during write", req_ready, 0);
      end
    end
    ref_mem[a] = d;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    dq_i = 8'hEE; p_wr_win = 1'b0; p_dq_oe = 1'b0; p_addr = '0; p_dq = '0;
    repeat (3) @(negedge clk);
    chk(ce_n && oe_n && we_n, "R1", "reset strobes", {ce_n, oe_n, we_n}, 3'b111);
    chk(!dq_oe && !rd_valid && req_ready, "R1", "reset outputs", {dq_oe, rd_valid, req_ready}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corners
    do_read(15'h0123, 1'b0);                 // unwritten location
    do_write(0, 8'h00);
    do_write(15'h7FFF, 8'hFF);
    do_read(0, 1'b0);
    do_read(15'h7FFF, 1'b0);
    do_write(15'h0123, 8'hA5);
    do_read(15'h0123, 1'b1);                 // R7: request held while busy
    do_read(15'h0122, 1'b0);

    // R8: linger instance keeps CE low for LG idle clocks after a write
    do_write(15'h2222, 8'h3C);
    for (int k = 1; k <= LG + 1; k++) begin
      @(negedge clk);
      if (k < LG) chk(lg_ce_n == 1'b0, "R8", "linger CE low", lg_ce_n, 0);
      else if (k == LG + 1) chk(lg_ce_n == 1'b1, "R8", "linger CE release", lg_ce_n, 1);
    end
    chk(ce_n == 1'b1, "R8", "default CE idle", ce_n, 1);

    // Constrained random mix
    for (int i = 0; i < 80; i++) begin
      int sel, a;
      sel = int'($urandom % 4);
      a = (sel == 0) ? 0 : (sel == 1) ? 15'h7FFF : int'($urandom % 16) * 97;
      if ($urandom % 2) do_write(a, 8'($urandom));
      else              do_read(a, 1'b0);
      if ($urandom % 3 == 0) @(negedge clk);
    end
    finish_run();
  end

endmodule